// File: doc/BRIEF.md
# Flash Self-Programming Control Register

This block is an 8-bit control and status register with a small sequencer. Together they decide when an on-chip flash controller may start a self-programming operation. Software writes one or more command bits in the same write as a global enable bit. That write arms the block for a short window of cycles. If a store-program strobe from the instruction decoder arrives inside the window, exactly one operation starts. The operation is one of: page load, page erase, page write, lock-bit programming, or re-enabling reads of the read-while-write section.

The block keeps a busy flag. While the flag is set, reads of the read-while-write section are blocked. The block also raises a ready interrupt and gives a short read window in which a program-memory read returns either lock bits or fuse bits. The flash array, the instruction decoder and the lock and fuse storage sit outside the block and connect through simple strobe and handshake ports.

The sequencer has three states:
- IDLE: nothing is armed.
- ARMED: the window is open.
- FLASH: a flash operation is running.

Its transitions are:
- arm: IDLE to ARMED.
- rearm: ARMED to ARMED, with a new command and a fresh window.
- accept-to-flash: ARMED to FLASH, for load, erase and write.
- accept-complete: ARMED to IDLE, for lock-bit set and read re-enable.
- disarm: ARMED to IDLE, when a write has the enable bit at 0.
- expire: ARMED to IDLE, when no strobe arrives in the window.
- done: FLASH to IDLE.

Top module: `spm_ctrl`

## Requirements
- R1: After reset, `reg_rdata` reads 0x00, and `spm_irq`, `fl_start`, `lock_wr`, `load_abort` and `rww_blocked` are all 0.
- R2: The register bits, from bit 7 down to bit 0, are: interrupt enable, busy, reserved, read re-enable, lock-bit set, page write, page erase, enable. Interrupt enable is read/write. Busy (bit 6) and reserved (bit 5) are read-only, and the reserved bit always reads 0. Bit 0 reads 1 from the arming write until the sequencer returns to IDLE.
- R3: `spm_irq` equals interrupt enable AND `gie` AND NOT enable.
- R4: A write with bit 0 set arms the selected command. A strobe sampled on the 1st to 4th clock edge after the write edge is accepted. With no strobe by the 4th edge, bits 4..0 read 0 from that edge onward, and later strobes start nothing.
- R5: When several of bits 4..1 are written together with bit 0, only the highest-priority one is kept and read back. The order is: bit 4 (read re-enable), bit 3 (lock set), bit 2 (page write), bit 1 (page erase), none (page load).
- R6: An accepted load, erase or write pulses `fl_start` for one cycle on the edge after the strobe. At the same time it presents `fl_op` (0 load, 1 erase, 2 write), `fl_addr` and `fl_wdata` from the strobe inputs. Bit 0 and the command bit stay set until `fl_done`, and then bits 4..0 read 0.
- R7: An accepted erase or write whose address is below `RWW_LIMIT` sets busy (bit 6 and `rww_blocked`). At or above the limit, busy is left unchanged.
- R8: Busy is cleared by an accepted read re-enable command after the operation has finished. It is also cleared by an accepted page load.
- R9: Writing read re-enable together with enable while a flash operation is running arms nothing and leaves busy and the register bits 6..0 unchanged.
- R10: A write with bit 4 set while a page load is buffered (from an accepted load until the next accepted page write) pulses `load_abort` for one cycle and discards the buffer. Any later such write gives no pulse.
- R11: An accepted lock-bit set pulses `lock_wr` for one cycle, with `lock_wdata` taken from the low byte of `spm_data`. It starts no flash operation and returns to IDLE.
- R12: After a lock-set arming write, a `lpm_strobe` on the 1st to 3rd cycle asserts `cfg_hit`. `cfg_rdata` then returns `fuse_bits` when `lpm_addr0` is 1 and `lock_bits` when it is 0. Otherwise `cfg_hit` is 0 and `cfg_rdata` is 0.
- R13: A write with bit 0 clear arms nothing and disarms a pending command, so a following strobe starts no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| gie | input | 1 | Global interrupt flag |
| spm_irq | output | 1 | Ready interrupt request |
| spm_strobe | input | 1 | Store-program instruction strobe |
| spm_addr | input | ADDR_W | Address that goes with the strobe |
| spm_data | input | DATA_W | Data word that goes with the strobe |
| lpm_strobe | input | 1 | Program-memory read strobe |
| lpm_addr0 | input | 1 | Bit 0 of the read address |
| cfg_hit | output | 1 | The read is served from lock or fuse bits |
| cfg_rdata | output | 8 | Lock or fuse byte returned |
| lock_bits | input | 8 | Current lock bits |
| fuse_bits | input | 8 | Current fuse bits |
| fl_start | output | 1 | Flash operation start pulse |
| fl_op | output | 2 | Flash operation code |
| fl_addr | output | ADDR_W | Flash operation address |
| fl_wdata | output | DATA_W | Flash operation data |
| fl_done | input | 1 | Flash operation finished |
| rww_blocked | output | 1 | Read-while-write section is blocked |
| load_abort | output | 1 | Page buffer discarded |
| lock_wr | output | 1 | Lock-bit program pulse |
| lock_wdata | output | 8 | Lock-bit value to program |

## Verification
The bench builds the block with an 8-bit address, `RWW_LIMIT` of 0x80, a 4-cycle arming window and a 3-cycle read window. With the 8-bit address, the section boundary can be tested on both sides, at 0x7F and 0x80. The short windows let the bench sweep the strobe and read delays across every edge from inside the window to past its end. The bench also sweeps all 16 combinations of command bits for priority, and all 8 combinations of enable, global flag and arming for the interrupt.

// File: rtl/spm_pkg.sv
`timescale 1ns/1ps
package spm_pkg;

    typedef enum logic [2:0] {
        CMD_LOAD,
        CMD_ERASE,
        CMD_WRITE,
        CMD_LOCK,
        CMD_RWWEN
    } spm_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_FLASH
    } spm_state_e;

    localparam int BIT_IE    = 7;
    localparam int BIT_BUSY  = 6;
    localparam int BIT_RWWEN = 4;
    localparam int BIT_LOCK  = 3;
    localparam int BIT_WRITE = 2;
    localparam int BIT_ERASE = 1;
    localparam int BIT_EN    = 0;

    localparam logic [1:0] FOP_LOAD  = 2'd0;
    localparam logic [1:0] FOP_ERASE = 2'd1;
    localparam logic [1:0] FOP_WRITE = 2'd2;

    // Readback image of bits 4..1 for a latched command
    function automatic logic [3:0] cmd_to_bits(input spm_cmd_e c);
        logic [3:0] b;
        b = 4'b0000;
        case (c)
            CMD_RWWEN: b = 4'b1000;
            CMD_LOCK:  b = 4'b0100;
            CMD_WRITE: b = 4'b0010;
            CMD_ERASE: b = 4'b0001;
            default:   b = 4'b0000;
        endcase
        return b;
    endfunction

    function automatic logic is_flash_op(input spm_cmd_e c);
        return (c == CMD_LOAD) || (c == CMD_ERASE) || (c == CMD_WRITE);
    endfunction

endpackage

// File: rtl/spm_cmd_sel.sv
`timescale 1ns/1ps
module spm_cmd_sel
    import spm_pkg::*;
(
    input  logic [4:1]  cmd_bits,
    output spm_cmd_e    cmd
);

    // Fixed priority: re-enable, lock set, write, erase, then load
    always_comb begin
        if (cmd_bits[BIT_RWWEN])
            cmd = CMD_RWWEN;
        else if (cmd_bits[BIT_LOCK])
            cmd = CMD_LOCK;
        else if (cmd_bits[BIT_WRITE])
            cmd = CMD_WRITE;
        else if (cmd_bits[BIT_ERASE])
            cmd = CMD_ERASE;
        else
            cmd = CMD_LOAD;
    end

endmodule

// File: rtl/spm_seq.sv
`timescale 1ns/1ps
module spm_seq
    import spm_pkg::*;
#(
    parameter int WIN_CYC = 4,
    parameter int CFG_CYC = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        arm,
    input  logic        disarm,
    input  spm_cmd_e    arm_cmd,
    input  logic        spm_strobe,
    input  logic        fl_done,
    output spm_state_e  state,
    output spm_cmd_e    cmd,
    output logic        go,
    output logic        cfg_open
);

    localparam int CW = $clog2(WIN_CYC + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(WIN_CYC - 1);
    localparam logic [CW-1:0] CNT_CFG  = CW'(CFG_CYC);

    spm_state_e     state_nx;
    spm_cmd_e       cmd_nx;
    logic [CW-1:0]  cnt, cnt_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cmd   <= CMD_LOAD;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cmd   <= cmd_nx;
            cnt   <= cnt_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        cmd_nx   = cmd;
        cnt_nx   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (arm) begin                      // arm
                    state_nx = ST_ARMED;
                    cmd_nx   = arm_cmd;
                    cnt_nx   = '0;
                end
            end
            ST_ARMED: begin
                if (spm_strobe) begin               // accept
                    state_nx = is_flash_op(cmd) ? ST_FLASH : ST_IDLE;
                end else if (arm) begin             // rearm
                    cmd_nx = arm_cmd;
                    cnt_nx = '0;
                end else if (disarm) begin          // disarm
                    state_nx = ST_IDLE;
                end else if (cnt == CNT_LAST) begin // expire
                    state_nx = ST_IDLE;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            ST_FLASH: begin
                if (fl_done)                        // done
                    state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        go       = (state == ST_ARMED) && spm_strobe;
        cfg_open = (state == ST_ARMED) && (cmd == CMD_LOCK) && (cnt < CNT_CFG);
    end

    a_r4_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED) |-> (cnt < CW'(WIN_CYC)))
        else $error("armed counter outside window");

endmodule

// File: rtl/spm_status.sv
`timescale 1ns/1ps
module spm_status
    import spm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      reg_wr,
    input  logic      wr_ie,
    input  logic      wr_rwwen,
    input  logic      go,
    input  spm_cmd_e  cmd,
    input  logic      in_rww,
    output logic      ie,
    output logic      busy,
    output logic      load_abort
);

    logic load_active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie          <= 1'b0;
            busy        <= 1'b0;
            load_active <= 1'b0;
            load_abort  <= 1'b0;
        end else begin
            load_abort <= 1'b0;
            if (reg_wr)
                ie <= wr_ie;

            if (go && (cmd == CMD_ERASE || cmd == CMD_WRITE) && in_rww)
                busy <= 1'b1;
            else if (go && (cmd == CMD_LOAD || cmd == CMD_RWWEN))
                busy <= 1'b0;

            if (go && cmd == CMD_LOAD)
                load_active <= 1'b1;
            else if (go && cmd == CMD_WRITE)
                load_active <= 1'b0;
            else if (reg_wr && wr_rwwen && load_active) begin
                load_active <= 1'b0;
                load_abort  <= 1'b1;
            end
        end
    end

    a_r10_abort_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        load_abort |-> ($past(reg_wr) && $past(wr_rwwen)))
        else $error("abort without a re-enable write");

endmodule

// File: rtl/spm_issue.sv
`timescale 1ns/1ps
module spm_issue
    import spm_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  spm_cmd_e          cmd,
    input  logic [ADDR_W-1:0] spm_addr,
    input  logic [DATA_W-1:0] spm_data,
    output logic              fl_start,
    output logic [1:0]        fl_op,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_wdata,
    output logic              lock_wr,
    output logic [7:0]        lock_wdata
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_start   <= 1'b0;
            fl_op      <= FOP_LOAD;
            fl_addr    <= '0;
            fl_wdata   <= '0;
            lock_wr    <= 1'b0;
            lock_wdata <= '0;
        end else begin
            fl_start <= 1'b0;
            lock_wr  <= 1'b0;
            if (go) begin
                unique case (cmd)
                    CMD_LOAD, CMD_ERASE, CMD_WRITE: begin
                        fl_start <= 1'b1;
                        fl_addr  <= spm_addr;
                        fl_wdata <= spm_data;
                        fl_op    <= (cmd == CMD_LOAD)  ? FOP_LOAD :
                                    (cmd == CMD_ERASE) ? FOP_ERASE : FOP_WRITE;
                    end
                    CMD_LOCK: begin
                        lock_wr    <= 1'b1;
                        lock_wdata <= spm_data[7:0];
                    end
                    default: ;
                endcase
            end
        end
    end

    a_r11_lock_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        lock_wr |-> !fl_start)
        else $error("lock and flash start together");

endmodule

// File: rtl/spm_ctrl.sv
`timescale 1ns/1ps
module spm_ctrl
    import spm_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 16,
    parameter logic [ADDR_W-1:0] RWW_LIMIT = 16'hE000,
    parameter int                WIN_CYC   = 4,
    parameter int                CFG_CYC   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              gie,
    output logic              spm_irq,
    input  logic              spm_strobe,
    input  logic [ADDR_W-1:0] spm_addr,
    input  logic [DATA_W-1:0] spm_data,
    input  logic              lpm_strobe,
    input  logic              lpm_addr0,
    output logic              cfg_hit,
    output logic [7:0]        cfg_rdata,
    input  logic [7:0]        lock_bits,
    input  logic [7:0]        fuse_bits,
    output logic              fl_start,
    output logic [1:0]        fl_op,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_wdata,
    input  logic              fl_done,
    output logic              rww_blocked,
    output logic              load_abort,
    output logic              lock_wr,
    output logic [7:0]        lock_wdata
);

    spm_cmd_e    arm_cmd, cmd;
    spm_state_e  state;
    logic        arm, disarm, go, cfg_open;
    logic        ie, busy, spmen, in_rww;
    logic        wdata_unused;

    assign wdata_unused = ^reg_wdata[6:5];
    assign arm    = reg_wr && reg_wdata[BIT_EN] && (state != ST_FLASH);
    assign disarm = reg_wr && !reg_wdata[BIT_EN];
    assign in_rww = (spm_addr < RWW_LIMIT);

    spm_cmd_sel u_sel (
        .cmd_bits (reg_wdata[4:1]),
        .cmd      (arm_cmd)
    );

    spm_seq #(.WIN_CYC(WIN_CYC), .CFG_CYC(CFG_CYC)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (arm),
        .disarm     (disarm),
        .arm_cmd    (arm_cmd),
        .spm_strobe (spm_strobe),
        .fl_done    (fl_done),
        .state      (state),
        .cmd        (cmd),
        .go         (go),
        .cfg_open   (cfg_open)
    );

    spm_status u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .wr_ie      (reg_wdata[BIT_IE]),
        .wr_rwwen   (reg_wdata[BIT_RWWEN]),
        .go         (go),
        .cmd        (cmd),
        .in_rww     (in_rww),
        .ie         (ie),
        .busy       (busy),
        .load_abort (load_abort)
    );

    spm_issue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_iss (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .cmd        (cmd),
        .spm_addr   (spm_addr),
        .spm_data   (spm_data),
        .fl_start   (fl_start),
        .fl_op      (fl_op),
        .fl_addr    (fl_addr),
        .fl_wdata   (fl_wdata),
        .lock_wr    (lock_wr),
        .lock_wdata (lock_wdata)
    );

    always_comb begin
        spmen       = (state != ST_IDLE);
        reg_rdata   = {ie, busy, 1'b0,
                       spmen ? cmd_to_bits(cmd) : 4'b0000, spmen};
        spm_irq     = ie && gie && !spmen;
        rww_blocked = busy;
        cfg_hit     = lpm_strobe && cfg_open;
        cfg_rdata   = cfg_hit ? (lpm_addr0 ? fuse_bits : lock_bits) : 8'h00;
    end

    a_r7_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (fl_start && fl_op != FOP_LOAD))
        else $error("busy rose without erase or write");

    a_r8_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(go))
        else $error("busy fell without an accepted command");

    a_r6_start_in_flash: assert property (@(posedge clk) disable iff (!rst_n)
        fl_start |-> (state == ST_FLASH))
        else $error("flash start outside the flash state");

    a_r11_lock_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        lock_wr |-> $past(spm_strobe))
        else $error("lock pulse without strobe");

endmodule

// File: tb/sim_spm_ctrl.sv
`timescale 1ns/1ps
module sim_spm_ctrl;

    localparam int AW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          gie = 1'b0;
    logic          spm_irq;
    logic          spm_strobe = 1'b0;
    logic [AW-1:0] spm_addr = '0;
    logic [DW-1:0] spm_data = '0;
    logic          lpm_strobe = 1'b0;
    logic          lpm_addr0 = 1'b0;
    logic          cfg_hit;
    logic [7:0]    cfg_rdata;
    logic [7:0]    lock_bits = 8'h3C;
    logic [7:0]    fuse_bits = 8'hC3;
    logic          fl_start;
    logic [1:0]    fl_op;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_wdata;
    logic          fl_done = 1'b0;
    logic          rww_blocked;
    logic          load_abort;
    logic          lock_wr;
    logic [7:0]    lock_wdata;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    spm_ctrl #(.ADDR_W(AW), .DATA_W(DW), .RWW_LIMIT(8'h80),
               .WIN_CYC(4), .CFG_CYC(3)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .gie(gie), .spm_irq(spm_irq),
        .spm_strobe(spm_strobe), .spm_addr(spm_addr), .spm_data(spm_data),
        .lpm_strobe(lpm_strobe), .lpm_addr0(lpm_addr0), .cfg_hit(cfg_hit),
        .cfg_rdata(cfg_rdata), .lock_bits(lock_bits), .fuse_bits(fuse_bits),
        .fl_start(fl_start), .fl_op(fl_op), .fl_addr(fl_addr),
        .fl_wdata(fl_wdata), .fl_done(fl_done), .rww_blocked(rww_blocked),
        .load_abort(load_abort), .lock_wr(lock_wr), .lock_wdata(lock_wdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Write lands on the next posedge; returns at the negedge after it
    task automatic wr(input logic [7:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic strobe(input logic [AW-1:0] a, input logic [DW-1:0] d);
        spm_strobe = 1'b1; spm_addr = a; spm_data = d;
        @(negedge clk);
        spm_strobe = 1'b0;
    endtask

    task automatic finish_op();
        fl_done = 1'b1;
        @(negedge clk);
        fl_done = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        #(200000.0);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [3:0] expb;
        repeat (3) @(negedge clk);
        check("R1 reset rdata", reg_rdata, 8'h00);
        check("R1 reset outputs", {spm_irq, fl_start, lock_wr, load_abort, rww_blocked}, 5'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 register bits: only bit 7 is writable without the enable bit
        wr(8'hE0);
        check("R2 ie rw, busy/rsv ro", reg_rdata, 8'h80);
        wr(8'h00);
        check("R2 ie cleared", reg_rdata, 8'h00);

        // R3 interrupt gating sweep
        for (int k = 0; k < 8; k++) begin
            gie = k[1];
            wr({k[2], 6'b0, k[0]});
            check("R3 irq gating", spm_irq, k[2] & k[1] & ~k[0]);
            repeat (5) @(negedge clk);
            check("R3 irq after window", spm_irq, k[2] & k[1]);
            check("R4 bits cleared after expiry", reg_rdata[4:0], 5'b0);
            wr(8'h00);
        end
        gie = 1'b0;

        // R4 strobe delay sweep with erase above the section limit
        for (int d = 1; d <= 6; d++) begin
            wr(8'h03);
            repeat (d - 1) @(negedge clk);
            strobe(8'h90, 16'h0000);
            check("R4 strobe accepted in window", fl_start, (d <= 4));
            if (d <= 4) begin
                check("R6 erase op code", fl_op, 2'd1);
                check("R6 enable held while busy", reg_rdata, 8'h03);
                check("R7 no busy above limit", rww_blocked, 1'b0);
                finish_op();
                check("R6 bits clear on done", reg_rdata, 8'h00);
            end else begin
                check("R4 expired reads zero", reg_rdata, 8'h00);
            end
        end

        // R4 exact expiry edge
        wr(8'h03);
        repeat (3) @(negedge clk);
        check("R4 still armed after edge 3", reg_rdata, 8'h03);
        @(negedge clk);
        check("R4 cleared at edge 4", reg_rdata, 8'h00);

        // R5 priority sweep over bits 4..1
        for (int b = 0; b < 16; b++) begin
            wr({3'b000, b[3:0], 1'b1});
            if (b[3])      expb = 4'b1000;
            else if (b[2]) expb = 4'b0100;
            else if (b[1]) expb = 4'b0010;
            else if (b[0]) expb = 4'b0001;
            else           expb = 4'b0000;
            check("R5 priority readback", reg_rdata[4:0], {expb, 1'b1});
            wr(8'h00);
            check("R13 disarm by write", reg_rdata, 8'h00);
        end

        // R13 write without enable arms nothing
        wr(8'h04);
        strobe(8'h10, 16'h1111);
        check("R13 no start without enable", fl_start, 1'b0);

        // R6 page load
        wr(8'h01);
        strobe(8'h10, 16'hBEEF);
        check("R6 load start", fl_start, 1'b1);
        check("R6 load op/addr/data", {fl_op, fl_addr, fl_wdata}, {2'd0, 8'h10, 16'hBEEF});
        check("R6 load readback", reg_rdata, 8'h01);
        finish_op();
        check("R6 load done", reg_rdata, 8'h00);

        // R7 page write in section sets busy
        wr(8'h05);
        strobe(8'h20, 16'h5A5A);
        check("R6 write op", fl_op, 2'd2);
        check("R7 busy set by write", {reg_rdata[6], rww_blocked}, 2'b11);
        // R9 re-enable during operation is ignored
        wr(8'h11);
        check("R9 re-enable ignored while busy", reg_rdata, 8'h45);
        check("R10 no abort after write consumed buffer", load_abort, 1'b0);
        finish_op();
        check("R9 busy persists after done", reg_rdata, 8'h40);
        // R8 re-enable sequence
        wr(8'h11);
        check("R8 re-enable armed", reg_rdata, 8'h51);
        strobe(8'h00, 16'h0000);
        check("R8 busy cleared", {reg_rdata, rww_blocked}, {8'h00, 1'b0});

        // R7 boundary
        wr(8'h03);
        strobe(8'h80, 16'h0);
        check("R7 at limit no busy", rww_blocked, 1'b0);
        finish_op();
        wr(8'h03);
        strobe(8'h7F, 16'h0);
        check("R7 below limit busy", rww_blocked, 1'b1);
        finish_op();

        // R8 page load clears busy
        wr(8'h01);
        strobe(8'h00, 16'h1234);
        check("R8 load clears busy", {reg_rdata, rww_blocked}, {8'h01, 1'b0});
        // R10 abort during load
        wr(8'h11);
        check("R10 abort pulse", load_abort, 1'b1);
        @(negedge clk);
        check("R10 abort single cycle", load_abort, 1'b0);
        finish_op();
        wr(8'h11);
        check("R10 no second abort", load_abort, 1'b0);
        wr(8'h00);

        // R11 lock-bit set
        wr(8'h09);
        strobe(8'h33, 16'h12A5);
        check("R11 lock pulse", {lock_wr, fl_start}, 2'b10);
        check("R11 lock data low byte", lock_wdata, 8'hA5);
        check("R11 returns idle", reg_rdata, 8'h00);

        // R12 read window sweep
        for (int d = 1; d <= 5; d++) begin
            for (int a = 0; a < 2; a++) begin
                wr(8'h09);
                repeat (d - 1) @(negedge clk);
                lpm_strobe = 1'b1; lpm_addr0 = a[0];
                #1;
                check("R12 cfg hit window", cfg_hit, (d <= 3));
                check("R12 cfg data", cfg_rdata,
                      (d <= 3) ? (a[0] ? 8'hC3 : 8'h3C) : 8'h00);
                @(negedge clk);
                lpm_strobe = 1'b0;
                wr(8'h00);
            end
        end

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule